// File: doc/BRIEF.md
# SIMD Signed Less-Than Compare Unit

This unit executes one vector instruction: a lane-by-lane signed "less than" comparison between two registers of a 32-entry, 128-bit vector register file. The instruction word carries the element size, so a single datapath handles 8-, 16-, 32- and 64-bit lanes. Each destination lane is written as a saturated mask: every bit set when the lane from the first source is the smaller one, every bit clear otherwise.

An instruction is presented for one cycle with a valid strobe. The sources are read combinationally. In the same cycle the unit decodes the word, checks the vector-unit enable and forms the mask. On the next clock edge it either commits the result to the destination register, or it raises one of two exception flags and writes nothing. The register file also has a fill port. Neighbouring units use it to deposit operands.

Top module: `vcmp_top`

## Requirements
- R1: Instruction bits are, from bit 31 down: [31:26] major opcode, which must be 6'b011110; [25:23] operation, which must be 3'b010; [22:21] format; [20:16] second source (compared against); [15:11] first source; [10:6] destination; [5:0] minor opcode, which must be 6'b001111.
- R2: The format code selects the lane width. 2'b00 gives 8-bit lanes (16 lanes), 2'b01 gives 16-bit (8 lanes), 2'b10 gives 32-bit (4 lanes) and 2'b11 gives 64-bit (2 lanes). Every lane of the 128-bit register is processed.
- R3: A destination lane becomes all ones when the first-source lane is less than the second-source lane, and all zeros otherwise. Equal lanes give all zeros.
- R4: Lanes are compared as two's-complement signed values. For example, an 8-bit lane holding 0x80 is less than one holding 0x7F.
- R5: When a valid, enabled, correctly decoded instruction is presented, the destination register and the outputs wb_en/wb_addr/wb_data update on the next rising edge. wb_en stays high for exactly one cycle.
- R6: When the destination names one of the sources, the result is computed from the source values held before the write.
- R7: A valid instruction with all three opcode fields matching, presented while vu_en is low, pulses exc_dis for one cycle and writes no register.
- R8: A valid instruction in which any of the major opcode, operation or minor opcode fields mismatches pulses exc_ri and writes no register, whatever the value of vu_en. exc_dis stays low.
- R9: No exception depends on the operand data. While instr_valid is low, no write and no exception occur.
- R10: Synchronous active-high reset clears every register of the file and drives wb_en, wb_addr, wb_data, exc_ri and exc_dis to zero.
- R11: The fill port writes fill_data into register fill_addr on the rising edge. If the fill and an instruction target the same register in the same cycle, the instruction result is what remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vu_en | input | 1 | Vector unit enable |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| fill_en | input | 1 | Register fill write enable |
| fill_addr | input | 5 | Register fill address |
| fill_data | input | 128 | Register fill data |
| wb_en | output | 1 | Result write committed this cycle |
| wb_addr | output | 5 | Destination register of the committed write |
| wb_data | output | 128 | Mask value written |
| exc_ri | output | 1 | Reserved-instruction exception pulse |
| exc_dis | output | 1 | Vector-unit-disabled exception pulse |

## Verification
The bench uses the default 128-bit register width and 32 registers. With these values every format has more than one lane: sixteen bytes down to two doublewords. A single operand pattern can therefore mix true and false lanes and put the sign bit at every lane boundary. Because the full register file is present, aliasing between destination and sources can be reached, as can a fill colliding with a write. The effect of a suppressed write is observed by reading the same register through a later compare.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    localparam int VLEN   = 128;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [5:0] MAJOR_OP = 6'b011110;
    localparam logic [2:0] OPER_OP  = 3'b010;
    localparam logic [5:0] MINOR_OP = 6'b001111;

    typedef enum logic [1:0] {
        FMT_B = 2'b00,
        FMT_H = 2'b01,
        FMT_W = 2'b10,
        FMT_D = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [5:0]        major;
        logic [2:0]        oper;
        fmt_e              fmt;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] dst;
        logic [5:0]        minor;
    } instr_t;

    typedef struct packed {
        logic              hit;
        logic              miss;
        fmt_e              fmt;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] dst;
    } dec_t;

    function automatic logic bytes_saturated(input logic [VLEN-1:0] v);
        for (int i = 0; i < VLEN / 8; i++) begin
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
    import vcmp_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] word,
    output dec_t        dec
);
    instr_t fields;
    logic   match;

    assign fields = instr_t'(word);
    assign match  = (fields.major == MAJOR_OP) &&
                    (fields.oper  == OPER_OP)  &&
                    (fields.minor == MINOR_OP);

    always_comb begin
        dec.hit   = valid && match;
        dec.miss  = valid && !match;
        dec.fmt   = fields.fmt;
        dec.src_b = fields.src_b;
        dec.src_a = fields.src_a;
        dec.dst   = fields.dst;
    end
endmodule

// File: rtl/vcmp_lanes.sv
module vcmp_lanes
    import vcmp_pkg::*;
#(
    parameter int WIDTH = VLEN
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  fmt_e             fmt,
    output logic [WIDTH-1:0] mask
);
    logic [3:0][WIDTH-1:0] per_fmt;

    for (genvar g = 0; g < 4; g++) begin : g_fmt
        localparam int LW = 8 << g;
        localparam int NL = WIDTH / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            assign per_fmt[g][l*LW +: LW] =
                {LW{$signed(opa[l*LW +: LW]) < $signed(opb[l*LW +: LW])}};
        end
    end

    assign mask = per_fmt[fmt];
endmodule

// File: rtl/vcmp_regfile.sv
module vcmp_regfile
    import vcmp_pkg::*;
#(
    parameter int WIDTH = VLEN,
    parameter int DEPTH = NREG,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic             ex_we,
    input  logic [AW-1:0]    ex_addr,
    input  logic [WIDTH-1:0] ex_data,
    input  logic             fl_we,
    input  logic [AW-1:0]    fl_addr,
    input  logic [WIDTH-1:0] fl_data
);
    logic [WIDTH-1:0] regs [DEPTH];

    assign rd_data_a = regs[rd_addr_a];
    assign rd_data_b = regs[rd_addr_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else begin
            if (fl_we) regs[fl_addr] <= fl_data;
            if (ex_we) regs[ex_addr] <= ex_data;
        end
    end

    AST_EXEC_OVER_FILL: assert property (@(posedge clk) disable iff (rst)
        (ex_we && fl_we && ex_addr == fl_addr) |=> regs[$past(ex_addr)] == $past(ex_data)); // R11
endmodule

// File: rtl/vcmp_top.sv
module vcmp_top
    import vcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vu_en,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    input  logic              fill_en,
    input  logic [RIDX_W-1:0] fill_addr,
    input  logic [VLEN-1:0]   fill_data,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_addr,
    output logic [VLEN-1:0]   wb_data,
    output logic              exc_ri,
    output logic              exc_dis
);
    dec_t            dec;
    logic [VLEN-1:0] src_a, src_b, mask;
    logic            commit;

    vcmp_decode u_decode (
        .valid (instr_valid),
        .word  (instr),
        .dec   (dec)
    );

    vcmp_regfile #(.WIDTH(VLEN), .DEPTH(NREG)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_addr_a (dec.src_a),
        .rd_addr_b (dec.src_b),
        .rd_data_a (src_a),
        .rd_data_b (src_b),
        .ex_we     (commit),
        .ex_addr   (dec.dst),
        .ex_data   (mask),
        .fl_we     (fill_en),
        .fl_addr   (fill_addr),
        .fl_data   (fill_data)
    );

    vcmp_lanes #(.WIDTH(VLEN)) u_lanes (
        .opa  (src_a),
        .opb  (src_b),
        .fmt  (dec.fmt),
        .mask (mask)
    );

    assign commit = dec.hit && vu_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en   <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
            exc_ri  <= 1'b0;
            exc_dis <= 1'b0;
        end else begin
            wb_en   <= commit;
            exc_ri  <= dec.miss;
            exc_dis <= dec.hit && !vu_en;
            if (commit) begin
                wb_addr <= dec.dst;
                wb_data <= mask;
            end
        end
    end

    AST_WB_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(instr_valid)); // R5
    AST_WB_DEST_FIELD: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_addr == $past(instr[10:6])); // R1
    AST_WB_MASK_SATURATED: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> bytes_saturated(wb_data)); // R3
    AST_NO_WRITE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(vu_en)); // R7
    AST_RI_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        exc_ri |-> !wb_en && !exc_dis); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(instr_valid) |-> !wb_en && !exc_ri && !exc_dis); // R9
endmodule

// File: tb/tb_vcmp_top.sv
module tb_vcmp_top;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst;
    logic         vu_en;
    logic         instr_valid;
    logic [31:0]  instr;
    logic         fill_en;
    logic [4:0]   fill_addr;
    logic [W-1:0] fill_data;
    logic         wb_en;
    logic [4:0]   wb_addr;
    logic [W-1:0] wb_data;
    logic         exc_ri;
    logic         exc_dis;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] mdl [32];

    always #2.5 clk = ~clk;

    vcmp_top dut (
        .clk, .rst, .vu_en, .instr_valid, .instr,
        .fill_en, .fill_addr, .fill_data,
        .wb_en, .wb_addr, .wb_data, .exc_ri, .exc_dis
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] f, input logic [4:0] b,
                                       input logic [4:0] a, input logic [4:0] d);
        return {6'b011110, 3'b010, f, b, a, d, 6'b001111};
    endfunction

    function automatic logic [W-1:0] ref_cmp(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [1:0] f);
        int lw = 8 << f;
        logic [W-1:0] res = '0;
        logic [W-1:0] lmask = (lw == 64) ? {64'd0, {64{1'b1}}} : ((W'(1) << lw) - 1);
        for (int l = 0; l < W / lw; l++) begin
            logic [63:0] xa = 64'(a >> (l * lw));
            logic [63:0] xb = 64'(b >> (l * lw));
            logic signed [63:0] sa = $signed(xa << (64 - lw)) >>> (64 - lw);
            logic signed [63:0] sb = $signed(xb << (64 - lw)) >>> (64 - lw);
            if (sa < sb) res = res | (lmask << (l * lw));
        end
        return res;
    endfunction

    task automatic fill(input logic [4:0] r, input logic [W-1:0] v);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = r; fill_data = v;
        @(negedge clk);
        fill_en = 1'b0;
        mdl[r] = v;
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1; instr = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic cmp(input string req, input logic [1:0] f, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b);
        logic [W-1:0] exp = ref_cmp(mdl[a], mdl[b], f);
        issue(mk(f, b, a, d));
        chk({req, " wb_en"}, W'(wb_en), W'(1));
        chk({req, " wb_addr"}, W'(wb_addr), W'(d));
        chk({req, " wb_data"}, wb_data, exp);
        chk({req, " no exc (R9)"}, W'({exc_ri, exc_dis}), W'(0));
        mdl[d] = exp;
    endtask

    task automatic t_reset();
        rst = 1'b1; vu_en = 1'b1; instr_valid = 1'b0; instr = '0;
        fill_en = 1'b0; fill_addr = '0; fill_data = '0;
        repeat (3) @(negedge clk);
        chk("R10 outputs", W'({wb_en, wb_addr, exc_ri, exc_dis}), W'(0));
        chk("R10 wb_data", wb_data, '0);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        cmp("R10 cleared file", 2'b00, 5'd30, 5'd20, 5'd21);
    endtask

    task automatic t_formats();
        fill(5'd1, 128'h807F00FF_01FE7F80_12345678_9ABCDEF0);
        fill(5'd2, 128'h7F80FF00_FE01807F_12345679_1ABCDEF0);
        cmp("R2 R3 byte", 2'b00, 5'd10, 5'd1, 5'd2);
        cmp("R2 R3 half", 2'b01, 5'd11, 5'd1, 5'd2);
        cmp("R2 R3 word", 2'b10, 5'd12, 5'd1, 5'd2);
        cmp("R2 R3 dword", 2'b11, 5'd13, 5'd1, 5'd2);
        cmp("R3 reversed byte", 2'b00, 5'd14, 5'd2, 5'd1);
        cmp("R3 equal lanes", 2'b10, 5'd15, 5'd1, 5'd1);
    endtask

    task automatic t_signed();
        fill(5'd3, {4{32'h8000_0000}});
        fill(5'd4, {4{32'h7FFF_FFFF}});
        issue(mk(2'b10, 5'd4, 5'd3, 5'd16));
        chk("R4 signed word", wb_data, {W{1'b1}});
        mdl[16] = {W{1'b1}};
        issue(mk(2'b00, 5'd4, 5'd3, 5'd17));
        chk("R4 signed byte", wb_data, {4{32'hFF00_0000}});
        mdl[17] = {4{32'hFF00_0000}};
        cmp("R4 dword", 2'b11, 5'd18, 5'd4, 5'd3);
    endtask

    task automatic t_alias();
        fill(5'd5, 128'h0102_F3F4_0506_F7F8_090A_FBFC_0D0E_FFF0);
        fill(5'd6, 128'hF102_0304_F506_0708_F90A_0B0C_FD0E_0F00);
        cmp("R6 dst equals first source", 2'b01, 5'd5, 5'd5, 5'd6);
        cmp("R6 dst equals second source", 2'b00, 5'd6, 5'd1, 5'd6);
        cmp("R5 R6 reread after write", 2'b00, 5'd19, 5'd5, 5'd6);
        @(negedge clk);
        chk("R5 single-cycle pulse", W'(wb_en), W'(0));
    endtask

    task automatic t_disabled();
        fill(5'd7, 128'h7F01_8002_0380_FF04_0506_80FF_0700_0801);
        vu_en = 1'b0;
        issue(mk(2'b00, 5'd2, 5'd1, 5'd7));
        chk("R7 exc_dis", W'(exc_dis), W'(1));
        chk("R7 no write / no ri", W'({wb_en, exc_ri}), W'(0));
        vu_en = 1'b1;
        cmp("R7 register kept", 2'b00, 5'd20, 5'd0, 5'd7);
    endtask

    task automatic t_reserved();
        logic [31:0] base = mk(2'b00, 5'd2, 5'd1, 5'd8);
        fill(5'd8, 128'h8081_0102_7F7E_FEFD_0001_8000_7FFF_0080);
        issue({6'b011111, base[25:0]});
        chk("R8 major mismatch", W'({exc_ri, exc_dis, wb_en}), W'(3'b100));
        issue({base[31:26], 3'b011, base[22:0]});
        chk("R8 operation mismatch", W'({exc_ri, exc_dis, wb_en}), W'(3'b100));
        vu_en = 1'b0;
        issue({base[31:6], 6'b001110});
        chk("R8 minor mismatch while disabled", W'({exc_ri, exc_dis, wb_en}), W'(3'b100));
        vu_en = 1'b1;
        cmp("R8 register kept", 2'b00, 5'd21, 5'd0, 5'd8);
    endtask

    task automatic t_idle();
        @(negedge clk);
        instr = mk(2'b00, 5'd2, 5'd1, 5'd9);
        instr_valid = 1'b0;
        @(negedge clk);
        chk("R9 no strobe, no action", W'({wb_en, exc_ri, exc_dis}), W'(0));
        instr = {6'b000000, 26'd0};
        @(negedge clk);
        chk("R9 no strobe, junk word", W'({wb_en, exc_ri, exc_dis}), W'(0));
    endtask

    task automatic t_fill_conflict();
        fill(5'd9, {16{8'h80}});
        @(negedge clk);
        instr_valid = 1'b1; instr = mk(2'b00, 5'd0, 5'd9, 5'd22);
        fill_en = 1'b1; fill_addr = 5'd22; fill_data = '0;
        @(negedge clk);
        instr_valid = 1'b0; fill_en = 1'b0;
        chk("R11 collision wb", wb_data, {W{1'b1}});
        mdl[22] = {W{1'b1}};
        cmp("R11 instruction wins", 2'b00, 5'd23, 5'd22, 5'd0);
        chk("R11 file holds mask", mdl[23], {W{1'b1}});
        fill(5'd24, 128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF);
        cmp("R11 fill visible", 2'b11, 5'd25, 5'd24, 5'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(5ns * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_formats();
        t_signed();
        t_alias();
        t_disabled();
        t_reserved();
        t_idle();
        t_fill_conflict();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule